// File: doc/BRIEF.md
# Processor Status Word Unit

This unit keeps the live status word of a processor core and one saved copy of it for each of the five exception modes. The live word holds four condition flags, two interrupt-disable bits, an instruction-set state bit and a five-bit mode field. The rest of the core sees the mode, the state bit, both interrupt masks and a privilege indication as plain outputs. The unit also returns the saved word that belongs to the mode the core is in now.

Four kinds of request can change the live word. The ALU can load new flags. Software can write the flag nibble and, from a privileged mode only, the control byte. A branch-with-exchange sets the state bit from bit 0 of the target value. In the same cycle the unit returns the target realigned as the next PC and raises a flush request. An exception entry saves the live word into the slot of the mode being entered and then switches to that mode.

Only one request takes effect in a cycle, with a fixed priority. Instruction decode, the ALU and the PC datapath sit outside this unit.

Top module: `psr_unit`

## Requirements
- R1: The first clock edge with `rst_n` low sets the live word to 0x000000D3 (supervisor mode, I and F set, T clear, flags clear) and clears every saved word.
- R2: Bits 27 to 8 of the live word always read as zero.
- R3: A flag update loads `flag_in` into bits 31..28 (N at 31, Z at 30, C at 29, V at 28) on the next edge and leaves the other bits unchanged.
- R4: A software write with `sw_flags_en` loads `sw_flags` into bits 31..28 in any mode. With `sw_ctrl_en`, it loads I (bit 7), F (bit 6) and T (bit 5) from `sw_ctrl[7:5]`, but only when the current mode is not user (0x10). In user mode, a control write leaves the low byte unchanged.
- R5: The legal mode codes are 0x10 user, 0x11 FIQ, 0x12 IRQ, 0x13 supervisor, 0x17 abort, 0x1B undefined and 0x1F system. A privileged control write with any other code in `sw_ctrl[4:0]` keeps the old mode field but still writes I, F and T.
- R6: While `bx_valid` is high, `bx_flush` is high and `bx_pc` equals `bx_target` with bit 0 cleared when bit 0 is 1, or with bits 1..0 cleared when bit 0 is 0. On the next edge, T takes `bx_target[0]` and the mode, flags and saved words do not change.
- R7: An exception request whose `exc_mode` is FIQ, IRQ, supervisor, abort or undefined copies the current live word into that mode's saved word. It sets the mode to `exc_mode`, clears T and sets I, and sets F as well when the target is FIQ. A request naming any other code has no effect.
- R8: `spsr_rd` shows the saved word of the current mode, and reads zero in user, system or any mode without a saved slot.
- R9: `irq_mask` equals I, `fiq_mask` equals F, `thumb` equals T, `mode` equals bits 4..0 and `privileged` is high exactly when the mode is not user.
- R10: When several requests arrive in the same cycle, only one takes effect, in the order: effective exception entry, then branch-with-exchange, then software write, then flag update. The others are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| flag_we | input | 1 | ALU flag update request |
| flag_in | input | 4 | New N, Z, C, V flags |
| sw_we | input | 1 | Software write request |
| sw_flags_en | input | 1 | Software write touches the flag nibble |
| sw_ctrl_en | input | 1 | Software write touches the control byte |
| sw_flags | input | 4 | Flag nibble to write |
| sw_ctrl | input | 8 | Control byte to write (I, F, T, mode) |
| bx_valid | input | 1 | Branch-with-exchange request |
| bx_target | input | 32 | Branch target register value |
| exc_valid | input | 1 | Exception entry request |
| exc_mode | input | 5 | Mode code of the exception being entered |
| cpsr | output | 32 | Live status word |
| mode | output | 5 | Current mode field |
| thumb | output | 1 | Instruction-set state bit T |
| irq_mask | output | 1 | Normal interrupt disabled |
| fiq_mask | output | 1 | Fast interrupt disabled |
| privileged | output | 1 | Current mode is not user |
| spsr_rd | output | 32 | Saved word of the current mode |
| bx_pc | output | 32 | Realigned branch target |
| bx_flush | output | 1 | Pipeline flush request |

## Verification
The bench builds the unit with its default 32-bit word and five saved slots. Every bank index is therefore reachable, and the saved-word read path can be checked for each exception mode and for the modes that have no slot. Because the width is the full word, the bench can push all-ones control bytes, odd and even branch targets, and illegal mode codes through the same model. A scripted pass covers each corner. A long pseudo-random pass then mixes simultaneous requests, so that user mode and every priority ordering are reached many times.

// File: rtl/psr_pkg.sv
`timescale 1ns/1ps
// Shared constants, mode codes and the status-word layout for the status unit.
// Assumes a 32-bit word with flags in the top nibble and control in the low byte.
package psr_pkg;

    localparam int PSR_W      = 32;
    localparam int MODE_W     = 5;
    localparam int FLAG_W     = 4;
    localparam int CTRL_W     = 8;
    localparam int NUM_BANKS  = 5;
    localparam int BANK_IDX_W = $clog2(NUM_BANKS);
    localparam int RSVD_W     = PSR_W - FLAG_W - CTRL_W;

    typedef enum logic [MODE_W-1:0] {
        MODE_USR = 5'h10,
        MODE_FIQ = 5'h11,
        MODE_IRQ = 5'h12,
        MODE_SVC = 5'h13,
        MODE_ABT = 5'h17,
        MODE_UND = 5'h1B,
        MODE_SYS = 5'h1F
    } mode_e;

    typedef struct packed {
        logic [FLAG_W-1:0] flags;    // N Z C V
        logic [RSVD_W-1:0] rsvd;
        logic              irq_off;
        logic              fiq_off;
        logic              thumb;
        logic [MODE_W-1:0] mode;
    } psr_t;

    localparam logic [PSR_W-1:0] PSR_RESET = 32'h0000_00D3;

    // True for the seven legal mode codes.
    function automatic logic psr_mode_legal(input logic [MODE_W-1:0] code);
        case (code)
            MODE_USR, MODE_FIQ, MODE_IRQ, MODE_SVC,
            MODE_ABT, MODE_UND, MODE_SYS: return 1'b1;
            default:                      return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/psr_mode_check.sv
`timescale 1ns/1ps
// Maps a mode code to its saved-word slot.
// Assumes slots are numbered FIQ, IRQ, SVC, ABT, UND; other codes have no slot.
module psr_mode_check
    import psr_pkg::*;
(
    input  logic [MODE_W-1:0]     code,
    output logic                  banked,
    output logic [BANK_IDX_W-1:0] bank
);

    // Decode the code into slot presence and slot number.
    always_comb begin
        banked = 1'b1;
        bank   = '0;
        case (code)
            MODE_FIQ: bank = BANK_IDX_W'(0);
            MODE_IRQ: bank = BANK_IDX_W'(1);
            MODE_SVC: bank = BANK_IDX_W'(2);
            MODE_ABT: bank = BANK_IDX_W'(3);
            MODE_UND: bank = BANK_IDX_W'(4);
            default:  banked = 1'b0;
        endcase
    end

endmodule

// File: rtl/psr_spsr_bank.sv
`timescale 1ns/1ps
// Storage for the saved status words, one register per exception mode.
// Assumes at most one write per cycle; reads are combinational.
module psr_spsr_bank #(
    parameter int NB = 5,
    parameter int W  = 32,
    localparam int IW = (NB > 1) ? $clog2(NB) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [W-1:0]  wr_data,
    input  logic          rd_en,
    input  logic [IW-1:0] rd_idx,
    output logic [W-1:0]  rd_data
);

    localparam logic [IW-1:0] LAST_IDX = IW'(NB - 1);

    logic [W-1:0] slot [NB];

    for (genvar g = 0; g < NB; g++) begin : g_slot
        // Hold one saved word; load it when this slot is addressed.
        always_ff @(posedge clk) begin
            if (!rst_n)
                slot[g] <= '0;
            else if (wr_en && wr_idx == IW'(g))
                slot[g] <= wr_data;
        end
    end

    // Return the addressed slot, or zero when there is none.
    always_comb begin
        rd_data = '0;
        if (rd_en && rd_idx <= LAST_IDX)
            rd_data = slot[rd_idx];
    end

endmodule

// File: rtl/psr_bx_align.sv
`timescale 1ns/1ps
// Realigns a branch-with-exchange target and extracts the new state bit.
// Assumes bit 0 of the target selects halfword (1) or word (0) alignment.
module psr_bx_align #(
    parameter int W = 32
) (
    input  logic [W-1:0] target,
    output logic [W-1:0] new_pc,
    output logic         to_thumb
);

    // Clear the alignment bits the selected state does not use.
    always_comb begin
        to_thumb = target[0];
        if (target[0])
            new_pc = {target[W-1:1], 1'b0};
        else
            new_pc = {target[W-1:2], 2'b00};
    end

endmodule

// File: rtl/psr_unit.sv
`timescale 1ns/1ps
// Live status word with saved copies per exception mode.
// Assumes at most one request acts per cycle; priority is exception entry,
// branch-with-exchange, software write, then ALU flag update.
module psr_unit
    import psr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flag_we,
    input  logic [FLAG_W-1:0] flag_in,
    input  logic              sw_we,
    input  logic              sw_flags_en,
    input  logic              sw_ctrl_en,
    input  logic [FLAG_W-1:0] sw_flags,
    input  logic [CTRL_W-1:0] sw_ctrl,
    input  logic              bx_valid,
    input  logic [PSR_W-1:0]  bx_target,
    input  logic              exc_valid,
    input  logic [MODE_W-1:0] exc_mode,
    output logic [PSR_W-1:0]  cpsr,
    output logic [MODE_W-1:0] mode,
    output logic              thumb,
    output logic              irq_mask,
    output logic              fiq_mask,
    output logic              privileged,
    output logic [PSR_W-1:0]  spsr_rd,
    output logic [PSR_W-1:0]  bx_pc,
    output logic              bx_flush
);

    psr_t                  cur_q, cur_d;
    logic                  cur_banked, exc_banked;
    logic [BANK_IDX_W-1:0] cur_bank, exc_bank;
    logic                  bx_thumb;
    logic                  exc_take;
    logic                  is_priv;

    psr_mode_check u_cur_mode (
        .code   (cur_q.mode),
        .banked (cur_banked),
        .bank   (cur_bank)
    );

    psr_mode_check u_exc_mode (
        .code   (exc_mode),
        .banked (exc_banked),
        .bank   (exc_bank)
    );

    psr_bx_align #(.W(PSR_W)) u_bx (
        .target   (bx_target),
        .new_pc   (bx_pc),
        .to_thumb (bx_thumb)
    );

    psr_spsr_bank #(.NB(NUM_BANKS), .W(PSR_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (exc_take),
        .wr_idx  (exc_bank),
        .wr_data (cur_q),
        .rd_en   (cur_banked),
        .rd_idx  (cur_bank),
        .rd_data (spsr_rd)
    );

    assign is_priv  = (cur_q.mode != MODE_USR);
    assign exc_take = exc_valid && exc_banked;

    // Pick the single winning request and form the next live word.
    always_comb begin
        cur_d = cur_q;
        if (exc_take) begin
            cur_d.mode    = exc_mode;
            cur_d.thumb   = 1'b0;
            cur_d.irq_off = 1'b1;
            if (exc_mode == MODE_FIQ)
                cur_d.fiq_off = 1'b1;
        end else if (bx_valid) begin
            cur_d.thumb = bx_thumb;
        end else if (sw_we) begin
            if (sw_flags_en)
                cur_d.flags = sw_flags;
            if (sw_ctrl_en && is_priv) begin
                cur_d.irq_off = sw_ctrl[7];
                cur_d.fiq_off = sw_ctrl[6];
                cur_d.thumb   = sw_ctrl[5];
                if (psr_mode_legal(sw_ctrl[MODE_W-1:0]))
                    cur_d.mode = sw_ctrl[MODE_W-1:0];
            end
        end else if (flag_we) begin
            cur_d.flags = flag_in;
        end
        cur_d.rsvd = '0;
    end

    // Live word register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cur_q <= psr_t'(PSR_RESET);
        else
            cur_q <= cur_d;
    end

    // Drive the decoded view of the live word.
    always_comb begin
        cpsr       = cur_q;
        mode       = cur_q.mode;
        thumb      = cur_q.thumb;
        irq_mask   = cur_q.irq_off;
        fiq_mask   = cur_q.fiq_off;
        privileged = is_priv;
        bx_flush   = bx_valid;
    end

    a_r2_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
        cpsr[27:8] == '0);

    a_r5_mode_legal: assert property (@(posedge clk) disable iff (!rst_n)
        psr_mode_legal(mode));

    a_r4_user_ctrl_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_USR && !exc_valid && !bx_valid)
        |=> cpsr[7:0] == $past(cpsr[7:0]));

    a_r6_bx_state: assert property (@(posedge clk) disable iff (!rst_n)
        (bx_valid && !exc_take)
        |=> (thumb == $past(bx_target[0])) && (mode == $past(mode))
            && (cpsr[31:28] == $past(cpsr[31:28])));

    a_r7_exc_saved: assert property (@(posedge clk) disable iff (!rst_n)
        exc_take |=> (spsr_rd == $past(cpsr)) && (mode == $past(exc_mode))
                     && irq_mask && !thumb);

endmodule

// File: tb/psr_unit_bench.sv
`timescale 1ns/1ps
// Self-checking bench: a behavioural model advanced on every clock and compared.
module psr_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        flag_we;
    logic [3:0]  flag_in;
    logic        sw_we, sw_flags_en, sw_ctrl_en;
    logic [3:0]  sw_flags;
    logic [7:0]  sw_ctrl;
    logic        bx_valid;
    logic [31:0] bx_target;
    logic        exc_valid;
    logic [4:0]  exc_mode;
    logic [31:0] cpsr, spsr_rd, bx_pc;
    logic [4:0]  mode;
    logic        thumb, irq_mask, fiq_mask, privileged, bx_flush;

    int checks = 0;
    int errors = 0;
    string phase = "R1";

    logic [31:0] m_cpsr;
    logic [31:0] m_spsr [32];
    logic [31:0] lfsr = 32'hACE1_2468;

    always #4 clk = ~clk;

    psr_unit u_psr_unit (
        .clk(clk), .rst_n(rst_n),
        .flag_we(flag_we), .flag_in(flag_in),
        .sw_we(sw_we), .sw_flags_en(sw_flags_en), .sw_ctrl_en(sw_ctrl_en),
        .sw_flags(sw_flags), .sw_ctrl(sw_ctrl),
        .bx_valid(bx_valid), .bx_target(bx_target),
        .exc_valid(exc_valid), .exc_mode(exc_mode),
        .cpsr(cpsr), .mode(mode), .thumb(thumb), .irq_mask(irq_mask),
        .fiq_mask(fiq_mask), .privileged(privileged), .spsr_rd(spsr_rd),
        .bx_pc(bx_pc), .bx_flush(bx_flush)
    );

    function automatic bit legal(input logic [4:0] c);
        return c == 5'h10 || c == 5'h11 || c == 5'h12 || c == 5'h13 ||
               c == 5'h17 || c == 5'h1B || c == 5'h1F;
    endfunction

    function automatic bit has_slot(input logic [4:0] c);
        return c == 5'h11 || c == 5'h12 || c == 5'h13 || c == 5'h17 || c == 5'h1B;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Advance the model by one clock edge from the inputs present now.
    task automatic model_edge();
        if (!rst_n) begin
            m_cpsr = 32'h0000_00D3;
            for (int i = 0; i < 32; i++) m_spsr[i] = '0;
        end else if (exc_valid && has_slot(exc_mode)) begin
            m_spsr[exc_mode] = m_cpsr;
            m_cpsr[7] = 1'b1;
            if (exc_mode == 5'h11) m_cpsr[6] = 1'b1;
            m_cpsr[5] = 1'b0;
            m_cpsr[4:0] = exc_mode;
        end else if (bx_valid) begin
            m_cpsr[5] = bx_target[0];
        end else if (sw_we) begin
            if (sw_flags_en) m_cpsr[31:28] = sw_flags;
            if (sw_ctrl_en && m_cpsr[4:0] != 5'h10) begin
                m_cpsr[7:5] = sw_ctrl[7:5];
                if (legal(sw_ctrl[4:0])) m_cpsr[4:0] = sw_ctrl[4:0];
            end
        end else if (flag_we) begin
            m_cpsr[31:28] = flag_in;
        end
    endtask

    task automatic compare();
        logic [31:0] exp_pc;
        chk(cpsr === m_cpsr, phase, "cpsr", cpsr, m_cpsr);
        chk(cpsr[27:8] === 20'h0, "R2", "reserved", {12'h0, cpsr[27:8]}, 32'h0);
        chk(mode === m_cpsr[4:0] && thumb === m_cpsr[5] && fiq_mask === m_cpsr[6]
            && irq_mask === m_cpsr[7] && privileged === (m_cpsr[4:0] != 5'h10),
            "R9", "decoded outputs",
            {mode, thumb, fiq_mask, irq_mask, privileged},
            {m_cpsr[4:0], m_cpsr[5], m_cpsr[6], m_cpsr[7], m_cpsr[4:0] != 5'h10});
        chk(spsr_rd === (has_slot(m_cpsr[4:0]) ? m_spsr[m_cpsr[4:0]] : 32'h0),
            "R8", "spsr_rd", spsr_rd,
            has_slot(m_cpsr[4:0]) ? m_spsr[m_cpsr[4:0]] : 32'h0);
        if (bx_valid) begin
            exp_pc = bx_target[0] ? {bx_target[31:1], 1'b0} : {bx_target[31:2], 2'b00};
            chk(bx_pc === exp_pc && bx_flush === 1'b1, "R6", "bx_pc/flush",
                bx_pc, exp_pc);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare();
    endtask

    task automatic idle();
        flag_we = 0; flag_in = 0; sw_we = 0; sw_flags_en = 0; sw_ctrl_en = 0;
        sw_flags = 0; sw_ctrl = 0; bx_valid = 0; bx_target = 0;
        exc_valid = 0; exc_mode = 0;
    endtask

    task automatic do_flags(input logic [3:0] f);
        idle(); flag_we = 1; flag_in = f; tick(); idle();
    endtask

    task automatic do_sw(input bit fe, input bit ce, input logic [3:0] f,
                         input logic [7:0] c);
        idle(); sw_we = 1; sw_flags_en = fe; sw_ctrl_en = ce;
        sw_flags = f; sw_ctrl = c; tick(); idle();
    endtask

    task automatic do_bx(input logic [31:0] t);
        idle(); bx_valid = 1; bx_target = t; tick(); idle();
    endtask

    task automatic do_exc(input logic [4:0] m);
        idle(); exc_valid = 1; exc_mode = m; tick(); idle();
    endtask

    initial begin
        #2_000_000;
        errors++; checks++;
        $display("FAIL watchdog expired actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        idle();
        rst_n = 0;
        @(negedge clk);
        phase = "R1";
        tick(); tick();
        chk(cpsr === 32'h0000_00D3, "R1", "reset word", cpsr, 32'h0000_00D3);
        rst_n = 1;
        tick();

        phase = "R3";
        do_flags(4'hA); do_flags(4'h5); do_flags(4'hF); do_flags(4'h0);

        phase = "R4";
        do_sw(1, 0, 4'h9, 8'h00);
        do_sw(0, 1, 4'h0, 8'h3F);          // I=0 F=0 T=1 system
        do_sw(1, 1, 4'h6, 8'hD3);
        phase = "R5";
        do_sw(0, 1, 4'h0, 8'h35);          // illegal code 0x15, keeps supervisor
        do_sw(0, 1, 4'h0, 8'h00);          // illegal code 0x00

        phase = "R6";
        do_bx(32'h0000_1235); do_bx(32'h0000_8006); do_bx(32'hFFFF_FFFF);
        do_bx(32'h1234_5673);

        phase = "R7";
        do_exc(5'h11); do_flags(4'h3); do_exc(5'h12); do_exc(5'h13);
        do_exc(5'h17); do_exc(5'h1B);
        do_exc(5'h10); do_exc(5'h1F); do_exc(5'h05);

        phase = "R4";
        do_sw(0, 1, 4'h0, 8'h10);          // drop to user
        do_sw(1, 1, 4'hC, 8'hFF);          // control ignored, flags written
        do_sw(0, 1, 4'h0, 8'h13);          // cannot climb back
        phase = "R8";
        do_flags(4'h7);
        do_bx(32'h0000_0041);
        phase = "R7";
        do_exc(5'h13);

        phase = "R10";
        idle(); exc_valid = 1; exc_mode = 5'h17; bx_valid = 1; bx_target = 32'h1;
        sw_we = 1; sw_flags_en = 1; sw_flags = 4'hE; flag_we = 1; flag_in = 4'h1;
        tick();
        idle(); bx_valid = 1; bx_target = 32'h3; sw_we = 1; sw_ctrl_en = 1;
        sw_ctrl = 8'h1F; flag_we = 1; flag_in = 4'h8;
        tick();
        idle(); sw_we = 1; sw_flags_en = 1; sw_flags = 4'h2; flag_we = 1;
        flag_in = 4'hD;
        tick();
        idle(); exc_valid = 1; exc_mode = 5'h1F; flag_we = 1; flag_in = 4'h4;
        tick();
        idle();

        phase = "R10";
        for (int n = 0; n < 3000; n++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            idle();
            flag_we     = lfsr[0];
            flag_in     = lfsr[7:4];
            sw_we       = lfsr[1];
            sw_flags_en = lfsr[8];
            sw_ctrl_en  = lfsr[9];
            sw_flags    = lfsr[15:12];
            sw_ctrl     = lfsr[23:16];
            bx_valid    = (lfsr[3:2] == 2'b11);
            bx_target   = {lfsr[15:0], lfsr[31:16]};
            exc_valid   = (lfsr[26:24] == 3'b101);
            case (lfsr[30:28])
                3'd0: exc_mode = 5'h11;
                3'd1: exc_mode = 5'h12;
                3'd2: exc_mode = 5'h13;
                3'd3: exc_mode = 5'h17;
                3'd4: exc_mode = 5'h1B;
                3'd5: exc_mode = 5'h10;
                3'd6: exc_mode = 5'h1F;
                default: exc_mode = lfsr[20:16];
            endcase
            tick();
        end
        idle();
        tick();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule